// File: doc/BRIEF.md
# Quadratic Feature Expansion Stream

This block turns one vector of DIM signed fixed-point samples into the second-order feature vector that a log-linearized mixture classifier weighs. A one-cycle start pulse loads the vector in parallel. The block then sends the expanded vector as a stream, one element per accepted cycle.

The stream has three parts, in this order:

- the constant one;
- the raw samples;
- every pairwise product x_i·x_j with i ≤ j.

Each element carries valid, a running index and a last flag. A multiply-accumulate stage downstream can therefore pair every element with its weight by index alone. A ready input lets that stage stall the stream at any point.

Products are formed at double width and brought back to the working format with an arithmetic right shift. Results that fall outside the working range saturate instead of wrapping. The total element count is H = 1 + DIM·(DIM+3)/2.

Top module: `qexp_stream`

## Requirements
- R1: A start pulse seen while no stream is in progress is accepted. In the next cycle valid_o is high, index_o is 0 and data_o is the constant one, which equals 2^FRAC_W.
- R2: Elements 1 to DIM carry the captured samples x1..xDIM in order. Sample k (counting from 1) is taken from bits [(k-1)·W +: W] of x_i, where W = INT_W + FRAC_W.
- R3: After the samples come the products for index pairs (i, j) with i ≤ j. The outer index i runs from 1 to DIM, and for each i the inner index j runs from i to DIM.
- R4: A product is the full 2W-bit signed product of its two samples, arithmetically shifted right by FRAC_W (rounding toward minus infinity). The result is clamped to the range [-2^(W-1), 2^(W-1)-1].
- R5: A stream holds exactly H elements. index_o runs 0..H-1 and rises by one after each handshake. last_o is high only on element H-1. valid_o is low in the cycle after the handshake of element H-1.
- R6: An element advances only on a cycle where valid_o and ready_i are both high. While ready_i is low, valid_o, data_o, index_o and last_o hold their values.
- R7: A start pulse that arrives while valid_o is high is ignored. The stream in progress carries on with its originally captured samples and does not restart.
- R8: During and right after synchronous reset, valid_o and last_o are low and index_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load pulse for the sample vector |
| x_i | input | DIM*(INT_W+FRAC_W) | Packed signed samples, x1 in the lowest field |
| ready_i | input | 1 | Downstream can accept an element |
| valid_o | output | 1 | An element is presented |
| data_o | output | INT_W+FRAC_W | Signed element value |
| index_o | output | $clog2(H) | Position of the element in the stream |
| last_o | output | 1 | Final element of the stream |

## Verification
The first element appears exactly one clock after the edge that samples an accepted start. Every later element appears one clock after the edge at which the element before it was handed over. The bench drives inputs and samples outputs on falling edges. It advances its expected element only when it saw valid_o and ready_i both high before the rising edge, so each check lands in the cycle its result is due. A stalled cycle is compared against the same expected element again, which also checks that the outputs hold.

// File: rtl/qexp_pkg.sv
package qexp_pkg;

    typedef enum logic [1:0] {
        PH_ONE  = 2'd0,
        PH_LIN  = 2'd1,
        PH_PROD = 2'd2
    } phase_e;

    // number of elements in the expanded vector
    function automatic int num_terms(input int d);
        return 1 + (d * (d + 3)) / 2;
    endfunction

    // width able to hold values 0..n-1 (at least one bit)
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/qexp_mul.sv
module qexp_mul #(
    parameter int W      = 12,
    parameter int FRAC_W = 8
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] y_o
);
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] MAXV = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [PW-1:0] a_ext, b_ext, prod, scaled;

    always_comb begin
        a_ext  = {{W{a_i[W-1]}}, a_i};
        b_ext  = {{W{b_i[W-1]}}, b_i};
        prod   = a_ext * b_ext;
        scaled = prod >>> FRAC_W;
        if (scaled > MAXV)      y_o = MAXV[W-1:0];
        else if (scaled < MINV) y_o = MINV[W-1:0];
        else                    y_o = scaled[W-1:0];
    end

    // R4: an out-of-range product must land on the matching bound
    always_comb begin
        if (scaled > MAXV)
            assert_no_overflow_R4: assert (y_o == MAXV[W-1:0]);
        if (scaled < MINV)
            assert_no_underflow_R4: assert (y_o == MINV[W-1:0]);
    end

endmodule

// File: rtl/qexp_seq.sv
module qexp_seq
    import qexp_pkg::*;
#(
    parameter int DIM   = 4,
    parameter int IDX_W = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    input  logic             ready_i,
    output logic             busy_o,
    output phase_e           phase_o,
    output logic [SEL_W-1:0] a_o,
    output logic [SEL_W-1:0] b_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam int H = num_terms(DIM);
    localparam logic [SEL_W-1:0] TOP = SEL_W'(DIM - 1);
    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(H - 1);

    logic fire;
    assign fire   = busy_o && ready_i;
    assign last_o = busy_o && (idx_o == END_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o  <= 1'b0;
            phase_o <= PH_ONE;
            a_o     <= '0;
            b_o     <= '0;
            idx_o   <= '0;
        end else if (!busy_o) begin
            if (launch_i) begin
                busy_o  <= 1'b1;
                phase_o <= PH_ONE;
                a_o     <= '0;
                b_o     <= '0;
                idx_o   <= '0;
            end
        end else if (fire) begin
            idx_o <= idx_o + 1'b1;
            unique case (phase_o)
                PH_ONE: begin
                    phase_o <= PH_LIN;
                    a_o     <= '0;
                end
                PH_LIN: begin
                    if (a_o == TOP) begin
                        phase_o <= PH_PROD;
                        a_o     <= '0;
                        b_o     <= '0;
                    end else begin
                        a_o <= a_o + 1'b1;
                    end
                end
                default: begin
                    if (b_o == TOP) begin
                        if (a_o == TOP) begin
                            busy_o <= 1'b0;
                            idx_o  <= '0;
                        end else begin
                            a_o <= a_o + 1'b1;
                            b_o <= a_o + 1'b1;
                        end
                    end else begin
                        b_o <= b_o + 1'b1;
                    end
                end
            endcase
        end
    end

    // R6: a stalled element holds its position
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ready_i) |=> (busy_o && $stable(idx_o) && $stable(a_o) && $stable(b_o)));

    // R5: index steps by one per handshake inside a stream
    assert_index_step_R5: assert property (@(posedge clk) disable iff (rst)
        (fire && !last_o) |=> (busy_o && idx_o == $past(idx_o) + 1'b1));

    // R5: the stream stops right after its last handshake
    assert_stream_end_R5: assert property (@(posedge clk) disable iff (rst)
        (fire && last_o) |=> !busy_o);

    // R5: the index-based last flag agrees with the pair counters
    assert_last_pair_R5: assert property (@(posedge clk) disable iff (rst)
        last_o |-> (phase_o == PH_PROD && a_o == TOP && b_o == TOP));

    // R3: the inner index never falls below the outer one
    assert_pair_order_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && phase_o == PH_PROD) |-> (b_o >= a_o));

endmodule

// File: rtl/qexp_stream.sv
module qexp_stream
    import qexp_pkg::*;
#(
    parameter int DIM    = 4,
    parameter int INT_W  = 4,
    parameter int FRAC_W = 8,
    localparam int W     = INT_W + FRAC_W,
    localparam int H     = num_terms(DIM),
    localparam int IDX_W = sel_width(H)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [DIM*W-1:0]      x_i,
    input  logic                  ready_i,
    output logic                  valid_o,
    output logic signed [W-1:0]   data_o,
    output logic [IDX_W-1:0]      index_o,
    output logic                  last_o
);
    localparam int SEL_W = sel_width(DIM);
    localparam logic signed [W-1:0] ONE = W'(1) << FRAC_W;

    logic signed [W-1:0] x_q [DIM];
    logic                busy, launch;
    phase_e              phase;
    logic [SEL_W-1:0]    sel_a, sel_b;
    logic signed [W-1:0] op_a, op_b, prod;

    assign launch = start_i && !busy;

    for (genvar k = 0; k < DIM; k++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)         x_q[k] <= '0;
            else if (launch) x_q[k] <= x_i[k*W +: W];
        end
    end

    qexp_seq #(
        .DIM   (DIM),
        .IDX_W (IDX_W),
        .SEL_W (SEL_W)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .launch_i (launch),
        .ready_i  (ready_i),
        .busy_o   (busy),
        .phase_o  (phase),
        .a_o      (sel_a),
        .b_o      (sel_b),
        .idx_o    (index_o),
        .last_o   (last_o)
    );

    assign op_a = x_q[sel_a];
    assign op_b = x_q[sel_b];

    qexp_mul #(
        .W      (W),
        .FRAC_W (FRAC_W)
    ) i_mul (
        .a_i (op_a),
        .b_i (op_b),
        .y_o (prod)
    );

    assign valid_o = busy;

    always_comb begin
        if (!busy) data_o = '0;
        else begin
            unique case (phase)
                PH_ONE:  data_o = ONE;
                PH_LIN:  data_o = op_a;
                default: data_o = prod;
            endcase
        end
    end

    // R1: an accepted start opens a stream at element 0
    assert_launch_R1: assert property (@(posedge clk) disable iff (rst)
        launch |=> (valid_o && index_o == '0 && data_o == ONE));

    // R7: a start during a stream leaves captured samples untouched
    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && start_i) |=> (valid_o || $past(last_o && ready_i)) && $stable(x_q[0]));

    // R6: stalled outputs stay put
    assert_stall_data_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o)));

endmodule

// File: tb/test_qexp_stream.sv
module test_qexp_stream;
    localparam int DIM = 4, INT_W = 4, FRAC_W = 8;
    localparam int W = INT_W + FRAC_W;
    localparam int H = 1 + DIM * (DIM + 3) / 2;
    localparam int IDX_W = $clog2(H);
    localparam int MAXV = (1 << (W - 1)) - 1;
    localparam int MINV = -(1 << (W - 1));

    logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, ready_i = 1'b0;
    logic [DIM*W-1:0] x_i = '0;
    logic valid_o, last_o;
    logic signed [W-1:0] data_o;
    logic [IDX_W-1:0] index_o;

    int total = 0, bad = 0, cyc = 0;

    always #10 clk = ~clk;

    qexp_stream #(.DIM(DIM), .INT_W(INT_W), .FRAC_W(FRAC_W)) i_qexp_stream (
        .clk(clk), .rst(rst), .start_i(start_i), .x_i(x_i), .ready_i(ready_i),
        .valid_o(valid_o), .data_o(data_o), .index_o(index_o), .last_o(last_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int sat_prod(input int a, input int b);
        longint p = longint'(a) * longint'(b);
        longint s = p >>> FRAC_W;
        if (s > MAXV) return MAXV;
        if (s < MINV) return MINV;
        return int'(s);
    endfunction

    function automatic int expect_elem(input int k, input int xs[DIM]);
        int n = DIM + 1;
        if (k == 0) return 1 << FRAC_W;
        if (k <= DIM) return xs[k-1];
        for (int i = 0; i < DIM; i++)
            for (int j = i; j < DIM; j++) begin
                if (n == k) return sat_prod(xs[i], xs[j]);
                n++;
            end
        return 0;
    endfunction

    function automatic logic [DIM*W-1:0] pack(input int xs[DIM]);
        logic [DIM*W-1:0] v = '0;
        for (int k = 0; k < DIM; k++) v[k*W +: W] = W'(xs[k]);
        return v;
    endfunction

    task automatic run_stream(input int xs[DIM], input int ready_pct, input int inject_at);
        int k = 0;
        string req;
        @(negedge clk);
        start_i = 1'b1;
        x_i = pack(xs);
        @(negedge clk);
        start_i = 1'b0;
        x_i = {$urandom, $urandom};
        while (k < H) begin
            if (k == 0) req = "R1";
            else if (k <= DIM) req = "R2";
            else req = "R3/R4";
            check({req, " valid (R6)"}, int'(valid_o), 1);
            check({req, " data"}, int'(data_o), expect_elem(k, xs));
            check("R5 index", int'(index_o), k);
            check("R5 last", int'(last_o), (k == H - 1) ? 1 : 0);
            // R7: a start pulse inside the stream must be ignored
            start_i = (k == inject_at);
            ready_i = (int'($urandom % 100) < ready_pct);
            if (ready_i) k++;
            @(negedge clk);
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        check("R5/R7 valid after last", int'(valid_o), 0);
    endtask

    initial begin
        int xs[DIM];
        void'($urandom(32'd2024));
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R8 valid", int'(valid_o), 0);
        check("R8 last", int'(last_o), 0);
        check("R8 index", int'(index_o), 0);
        @(negedge clk);
        check("R8 idle without start", int'(valid_o), 0);

        xs = '{0, 0, 0, 0};
        run_stream(xs, 100, -1);
        xs = '{256, -256, 512, 128};
        run_stream(xs, 100, 3);
        // R4: saturation corners
        xs = '{MAXV, MINV, MAXV, MINV};
        run_stream(xs, 60, 7);
        xs = '{MINV, MINV, 1, -1};
        run_stream(xs, 50, -1);
        xs = '{-1, -1, 255, -257};
        run_stream(xs, 70, 14);

        for (int t = 0; t < 30; t++) begin
            for (int k = 0; k < DIM; k++) xs[k] = int'($urandom % (1 << W)) + MINV;
            run_stream(xs, 40 + int'($urandom % 61), int'($urandom % H));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule